// File: doc/BRIEF.md
# Complementary Output Short Detector

This block watches three pairs of complementary PWM drive signals, one high-side and one low-side output per bridge leg. It reports a shoot-through condition whenever both outputs of a pair are at their active level at once. Each pin has its own polarity bit, so active-high and active-low gate drives can be mixed. Each pair has its own enable.

The six pin levels are compared in a registered stage. Each pair then has its own two-state machine. The state `LEG_ARMED` means no fault is held, and `LEG_LATCHED` means a short was seen and is being held. Transition `ARM_TO_LATCH` is taken at the clock edge where the registered overlap of an armed pair is high. Transition `LATCH_TO_ARM` is taken at an edge where `clear_i` is high and the registered overlap of that pair is low. In every other case each state holds.

The latched flags of the enabled pairs are combined into one high-impedance request, which should tristate the complementary outputs. A one-cycle interrupt pulse marks each new latch.

Top module: `cpwm_short_guard`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `short_flag_o`, `hiz_req_o` and `irq_o` are all low.
- R2: Pin `i` is active when `pin_level_i[i]` equals `pol_i[i]` (1 = active high, 0 = active low). Pair `p` uses pin `2p` as its high side and pin `2p+1` as its low side. An overlap exists when both pins of an enabled pair are active.
- R3: An overlap present at one rising edge, even for that single cycle, makes `short_flag_o[p]` high right after the next rising edge.
- R4: Once set, `short_flag_o[p]` stays high after the overlap ends, until it is cleared.
- R5: `clear_i` sampled high at an edge clears a set flag only when the overlap of that pair was absent at the previous edge. A clear during an overlap has no effect.
- R6: A pair whose `pair_en_i` bit is low never sets its flag, whatever its pin levels are.
- R7: `hiz_req_o` is high exactly when some pair has both its flag and its enable bit high.
- R8: `irq_o` is high for the single cycle in which any flag goes from low to high, and is low otherwise.
- R9: The pairs are independent. An overlap or clear on one pair leaves the flags of the other pairs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_level_i | input | 6 | Observed output levels, high side at even index |
| pol_i | input | 6 | Per-pin active level, 1 = high |
| pair_en_i | input | 3 | Per-pair monitor enable |
| clear_i | input | 1 | Flag clear strobe |
| short_flag_o | output | 3 | Sticky per-pair short flags |
| hiz_req_o | output | 1 | High-impedance request |
| irq_o | output | 1 | Interrupt pulse on a new short |

## Verification
The stimulus starts with legal complementary patterns, where only one side of each pair is active. These must never trip, which separates a real overlap test from a test of single-pin levels. A single-cycle overlap is then compared with a held overlap, which shows the one-cycle sensitivity, the sticky hold and the single interrupt pulse. Active-low pins are driven both idle and shorted, which shows that polarity is applied per pin and not per pair. Clears issued during and after an overlap, and overlaps on a disabled pair, separate the clear and enable gating from the plain latch.

// File: rtl/cpwm_guard_pkg.sv
package cpwm_guard_pkg;
    typedef enum logic {
        LEG_ARMED   = 1'b0,
        LEG_LATCHED = 1'b1
    } leg_state_t;
endpackage

// File: rtl/cpwm_overlap_cmp.sv
module cpwm_overlap_cmp #(
    parameter int NUM_PAIRS = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [2*NUM_PAIRS-1:0] pin_level_i,
    input  logic [2*NUM_PAIRS-1:0] pol_i,
    input  logic [NUM_PAIRS-1:0]   pair_en_i,
    output logic [NUM_PAIRS-1:0]   overlap_q_o
);
    localparam int NUM_PINS = 2 * NUM_PAIRS;

    logic [NUM_PINS-1:0]  pin_active;
    logic [NUM_PAIRS-1:0] overlap_d;

    // A pin is active when its level matches its polarity bit.
    assign pin_active = ~(pin_level_i ^ pol_i);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign overlap_d[p] = pair_en_i[p] & pin_active[2*p] & pin_active[2*p+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) overlap_q_o <= '0;
        else         overlap_q_o <= overlap_d;
    end
endmodule

// File: rtl/cpwm_leg_fsm.sv
module cpwm_leg_fsm
    import cpwm_guard_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic overlap_i,
    input  logic clear_i,
    output logic flag_o,
    output logic rise_o
);
    leg_state_t state_q, state_d;
    logic       rise_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_ARMED:   if (overlap_i)             state_d = LEG_LATCHED; // ARM_TO_LATCH
            LEG_LATCHED: if (clear_i && !overlap_i) state_d = LEG_ARMED;   // LATCH_TO_ARM
            default:                                state_d = LEG_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LEG_ARMED;
        else         state_q <= state_d;
    end

    // Output register: one-cycle pulse on the latch transition
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rise_q <= 1'b0;
        else         rise_q <= (state_q == LEG_ARMED) && (state_d == LEG_LATCHED);
    end

    assign flag_o = (state_q == LEG_LATCHED);
    assign rise_o = rise_q;
endmodule

// File: rtl/cpwm_req_merge.sv
module cpwm_req_merge #(
    parameter int NUM_PAIRS = 3
) (
    input  logic [NUM_PAIRS-1:0] flag_i,
    input  logic [NUM_PAIRS-1:0] rise_i,
    input  logic [NUM_PAIRS-1:0] pair_en_i,
    output logic                 hiz_req_o,
    output logic                 irq_o
);
    assign hiz_req_o = |(flag_i & pair_en_i);
    assign irq_o     = |rise_i;
endmodule

// File: rtl/cpwm_short_guard.sv
module cpwm_short_guard #(
    parameter int NUM_PAIRS = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [2*NUM_PAIRS-1:0] pin_level_i,
    input  logic [2*NUM_PAIRS-1:0] pol_i,
    input  logic [NUM_PAIRS-1:0]   pair_en_i,
    input  logic                   clear_i,
    output logic [NUM_PAIRS-1:0]   short_flag_o,
    output logic                   hiz_req_o,
    output logic                   irq_o
);
    logic [NUM_PAIRS-1:0] overlap_q;
    logic [NUM_PAIRS-1:0] rise;

    cpwm_overlap_cmp #(.NUM_PAIRS(NUM_PAIRS)) u_cmp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_level_i (pin_level_i),
        .pol_i       (pol_i),
        .pair_en_i   (pair_en_i),
        .overlap_q_o (overlap_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_leg
        cpwm_leg_fsm u_fsm (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .overlap_i (overlap_q[p]),
            .clear_i   (clear_i),
            .flag_o    (short_flag_o[p]),
            .rise_o    (rise[p])
        );
    end

    cpwm_req_merge #(.NUM_PAIRS(NUM_PAIRS)) u_merge (
        .flag_i    (short_flag_o),
        .rise_i    (rise),
        .pair_en_i (pair_en_i),
        .hiz_req_o (hiz_req_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/cpwm_short_guard_chk.sv
module cpwm_short_guard_chk #(
    parameter int NUM_PAIRS = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_PAIRS-1:0] pair_en_i,
    input logic                 clear_i,
    input logic [NUM_PAIRS-1:0] short_flag_o,
    input logic                 hiz_req_o,
    input logic                 irq_o,
    input logic [NUM_PAIRS-1:0] overlap_q
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        // R3: a registered overlap latches the flag at the next edge
        p_overlap_latches_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            overlap_q[p] |=> short_flag_o[p]);
        // R4: a flag holds without a clear
        p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (short_flag_o[p] && !clear_i) |=> short_flag_o[p]);
        // R5: a clear without an overlap removes the flag
        p_clear_works_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (short_flag_o[p] && clear_i && !overlap_q[p]) |=> !short_flag_o[p]);
        // R6: only an enabled pair produces an overlap
        p_disabled_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            overlap_q[p] |-> $past(pair_en_i[p]));
        // R8: each new flag comes with an interrupt pulse
        p_rise_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(short_flag_o[p]) |-> irq_o);
    end

    // R7: a request needs at least one latched flag
    p_hiz_has_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hiz_req_o |-> (short_flag_o != '0));
    // R8: an interrupt never lasts two cycles
    p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o || (short_flag_o != $past(short_flag_o)));
endmodule

bind cpwm_short_guard cpwm_short_guard_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pair_en_i    (pair_en_i),
    .clear_i      (clear_i),
    .short_flag_o (short_flag_o),
    .hiz_req_o    (hiz_req_o),
    .irq_o        (irq_o),
    .overlap_q    (overlap_q)
);

// File: tb/cpwm_short_guard_bench.sv
module cpwm_short_guard_bench;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*NP-1:0] lvl = '0;
    logic [2*NP-1:0] pol = '1;
    logic [NP-1:0]   en = '1;
    logic            clr = 1'b0;
    logic [NP-1:0]   flag;
    logic            hiz, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [NP-1:0] flag;
        logic          hiz;
        logic          irq;
        string         tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [NP-1:0] m_ovl = '0;
    logic [NP-1:0] m_flag = '0;

    always #2 clk = ~clk;

    cpwm_short_guard #(.NUM_PAIRS(NP)) u_cpwm_short_guard (
        .clk_i(clk), .rst_ni(rst_n), .pin_level_i(lvl), .pol_i(pol),
        .pair_en_i(en), .clear_i(clr), .short_flag_o(flag),
        .hiz_req_o(hiz), .irq_o(irq)
    );

    task automatic step(input logic [2*NP-1:0] l, input logic [2*NP-1:0] pl,
                        input logic [NP-1:0] e, input logic c, input string tag);
        exp_t x;
        logic [NP-1:0] nf, no;
        logic ni;
        @(negedge clk);
        lvl = l; pol = pl; en = e; clr = c;
        ni = 1'b0;
        for (int p = 0; p < NP; p++) begin
            nf[p] = m_flag[p] ? !(c && !m_ovl[p]) : m_ovl[p];
            if (!m_flag[p] && m_ovl[p]) ni = 1'b1;
            no[p] = e[p] && (l[2*p] == pl[2*p]) && (l[2*p+1] == pl[2*p+1]);
        end
        x.flag = nf; x.irq = ni; x.hiz = |(nf & e); x.tag = tag;
        q.push_back(x);
        m_flag = nf; m_ovl = no;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                n_cmp++;
                if (flag !== x.flag || hiz !== x.hiz || irq !== x.irq) begin
                    n_bad++;
                    $display("FAIL %s: flag=%b hiz=%b irq=%b expected flag=%b hiz=%b irq=%b",
                             x.tag, flag, hiz, irq, x.flag, x.hiz, x.irq);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (flag !== '0 || hiz !== 1'b0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: flag=%b hiz=%b irq=%b expected 000/0/0", flag, hiz, irq);
        end
        rst_n = 1'b1;
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R1");
        // R2: legal complementary patterns never trip
        step(6'b101010, 6'b111111, 3'b111, 1'b0, "R2");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R2");
        step(6'b000000, 6'b111111, 3'b111, 1'b0, "R2");
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R2");
        // R3/R8: single-cycle overlap on pair 0
        step(6'b010111, 6'b111111, 3'b111, 1'b0, "R3");
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R3");
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R8");
        // R4: sticky hold, R9 others untouched
        repeat (4) step(6'b010101, 6'b111111, 3'b111, 1'b0, "R4");
        // R5: clear during a held overlap is ignored
        step(6'b010111, 6'b111111, 3'b111, 1'b0, "R5");
        step(6'b010111, 6'b111111, 3'b111, 1'b1, "R5");
        step(6'b010111, 6'b111111, 3'b111, 1'b1, "R5");
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R5");
        step(6'b010101, 6'b111111, 3'b111, 1'b1, "R5");
        step(6'b010101, 6'b111111, 3'b111, 1'b0, "R5");
        // R2: pair 1 active low: both pins high is idle, both low is a short
        step(6'b011101, 6'b110011, 3'b111, 1'b0, "R2");
        step(6'b010001, 6'b110011, 3'b111, 1'b0, "R2");
        step(6'b010001, 6'b110011, 3'b111, 1'b0, "R2");
        step(6'b011001, 6'b110011, 3'b111, 1'b0, "R9");
        // R6: disabled pair 2 overlapping for several cycles
        repeat (4) step(6'b111001, 6'b110011, 3'b011, 1'b0, "R6");
        step(6'b011001, 6'b110011, 3'b011, 1'b1, "R9");
        step(6'b011001, 6'b110011, 3'b111, 1'b0, "R6");
        // R7: latch pair 2, then disable it to drop the request
        step(6'b111001, 6'b111111, 3'b111, 1'b0, "R7");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R7");
        step(6'b011001, 6'b111111, 3'b011, 1'b0, "R7");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R7");
        // R8/R9: two pairs shorting together give one pulse
        step(6'b011111, 6'b111111, 3'b111, 1'b1, "R8");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R8");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R8");
        step(6'b011001, 6'b111111, 3'b111, 1'b1, "R9");
        step(6'b011001, 6'b111111, 3'b111, 1'b0, "R9");
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule